// File: doc/BRIEF.md
# Comma Aligner and Word Checker

This block sits behind a clock-and-data recovery stage. It takes one recovered serial bit per clock and shifts it into a ten-bit window. When the oldest seven bits of the window form a comma, that is taken as a word boundary. The window contents at that moment are captured as an aligned word, and a bit counter is restarted. Each following group of ten bits is then captured on the counter's wrap. The captured ten-bit words go out to an external 8b/10b decoder.

The decoder returns a byte with a parity bit. In data mode the block checks the parity, compares the byte with the byte the transmitter sent, and emits a one-cycle pulse on either a shared "hit" output (the word matched) or a "fault" output (it did not). In comma mode the same hit output instead pulses once for every detected comma. This lets a pulse counter outside the chip measure either comma lock or the word error rate from a single pin.

Top module: `comma_word_checker`

## Requirements
- R1: A comma is recognised when the seven oldest window bits, first-received bit first, equal 0011111 or 1100000. Bits enter one per clock, and `word_out[9]` holds the earliest of the ten captured bits.
- R2: On a comma, the ten-bit window containing it is driven on `word_out`, with `word_valid` high for one cycle. This happens in the cycle after the clock edge that shifted in the comma word's last bit.
- R3: After a boundary, a new word is captured every ten bits. A comma arriving at any other offset moves the boundary to itself.
- R4: From reset until the first comma, `word_valid`, `hit_pulse`, `fault_pulse` and `parity_err_pulse` stay low, even when `dec_valid` is asserted in data mode.
- R5: In comma mode (`data_mode`=0), `hit_pulse` rises for one cycle after each comma. `fault_pulse` and `parity_err_pulse` stay low whatever the decoder interface presents.
- R6: In data mode, when `dec_valid` is high, the parity is good and `dec_byte` equals `tx_byte`, `hit_pulse` is high in the following cycle.
- R7: In data mode, when `dec_valid` is high and the parity is bad or the bytes differ, `fault_pulse` is high in the following cycle. `hit_pulse` and `fault_pulse` are never high together.
- R8: Parity is even over the nine bits {`dec_byte`, `dec_parity`}. A violation with `dec_valid` high in data mode raises `parity_err_pulse` in the following cycle, together with `fault_pulse`.
- R9: Each pulse lasts one cycle. With `dec_valid` low in data mode, no pulse follows.
- R10: In data mode a comma still realigns and captures its word, but it does not pulse `hit_pulse`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| data_mode | input | 1 | 0 = comma mode, 1 = data mode |
| rx_bit | input | 1 | Recovered serial bit, one per cycle |
| dec_valid | input | 1 | Decoder result valid |
| dec_byte | input | 8 | Decoded byte |
| dec_parity | input | 1 | Parity bit accompanying the decoded byte |
| tx_byte | input | 8 | Byte the transmitter sent for this word |
| word_out | output | 10 | Last aligned ten-bit word |
| word_valid | output | 1 | One-cycle strobe: new aligned word |
| hit_pulse | output | 1 | Comma seen (comma mode) or word matched (data mode) |
| fault_pulse | output | 1 | Received word wrong |
| parity_err_pulse | output | 1 | Parity violation |

## Verification
The hardest situation to reach is a boundary moving mid-stream. That needs a comma placed at an offset that does not coincide with the running ten-bit count, while no accidental comma forms across word edges. The stimulus feeds an alternating filler pattern, which can never contain five equal bits in a row. It then inserts three stray bits ahead of a comma and checks that the following data word is captured on the new boundary. The locked-before-comma rule is exercised by pushing decoder results in data mode while only filler has arrived.

// File: rtl/cwc_pkg.sv
package cwc_pkg;
  localparam int WORD_W  = 10;
  localparam int BYTE_W  = 8;
  localparam int COMMA_W = 7;
  localparam logic [COMMA_W-1:0] COMMA_POS = 7'b0011111;
  localparam logic [COMMA_W-1:0] COMMA_NEG = 7'b1100000;

  // True when the seven oldest window bits form either comma polarity.
  function automatic logic is_comma(input logic [COMMA_W-1:0] head);
    return (head == COMMA_POS) || (head == COMMA_NEG);
  endfunction

  // Even parity across byte and parity bit.
  function automatic logic parity_good(input logic [BYTE_W-1:0] b, input logic p);
    return ((^b) ^ p) == 1'b0;
  endfunction
endpackage

// File: rtl/cwc_window_align.sv
module cwc_window_align
  import cwc_pkg::*;
#(
  parameter int WW = WORD_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_bit,
  output logic          comma_hit,
  output logic          locked,
  output logic [WW-1:0] word_q,
  output logic          word_valid_q
);
  localparam int CNT_W = $clog2(WW);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WW - 1);

  logic [WW-1:0]    win;
  logic [CNT_W-1:0] cnt;
  logic             strobe;

  assign comma_hit = is_comma(win[WW-1 -: COMMA_W]);
  assign strobe    = comma_hit || (locked && (cnt == LAST));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      win          <= '0;
      cnt          <= '0;
      locked       <= 1'b0;
      word_q       <= '0;
      word_valid_q <= 1'b0;
    end else begin
      win          <= {win[WW-2:0], rx_bit};
      locked       <= locked | comma_hit;
      word_valid_q <= strobe;
      if (strobe) begin
        cnt    <= '0;
        word_q <= win;
      end else if (locked) begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/cwc_word_check.sv
module cwc_word_check
  import cwc_pkg::*;
#(
  parameter int BW = BYTE_W
) (
  input  logic          enable,
  input  logic          dec_valid,
  input  logic [BW-1:0] dec_byte,
  input  logic          dec_parity,
  input  logic [BW-1:0] tx_byte,
  output logic          good_w,
  output logic          bad_w,
  output logic          par_bad_w
);
  logic live, pok, same;

  assign live      = enable && dec_valid;
  assign pok       = parity_good(dec_byte, dec_parity);
  assign same      = (dec_byte == tx_byte);
  assign good_w    = live && pok && same;
  assign bad_w     = live && !(pok && same);
  assign par_bad_w = live && !pok;
endmodule

// File: rtl/cwc_pulse_out.sv
module cwc_pulse_out (
  input  logic clk,
  input  logic rst_n,
  input  logic data_mode,
  input  logic comma_hit,
  input  logic good_w,
  input  logic bad_w,
  input  logic par_bad_w,
  output logic hit_q,
  output logic fault_q,
  output logic par_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hit_q   <= 1'b0;
      fault_q <= 1'b0;
      par_q   <= 1'b0;
    end else begin
      hit_q   <= data_mode ? good_w : comma_hit;
      fault_q <= bad_w;
      par_q   <= par_bad_w;
    end
  end
endmodule

// File: rtl/comma_word_checker.sv
module comma_word_checker
  import cwc_pkg::*;
#(
  parameter int WW = WORD_W,
  parameter int BW = BYTE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          data_mode,
  input  logic          rx_bit,
  input  logic          dec_valid,
  input  logic [BW-1:0] dec_byte,
  input  logic          dec_parity,
  input  logic [BW-1:0] tx_byte,
  output logic [WW-1:0] word_out,
  output logic          word_valid,
  output logic          hit_pulse,
  output logic          fault_pulse,
  output logic          parity_err_pulse
);
  logic comma_hit_w, locked_w, good_w, bad_w, par_bad_w;

  cwc_window_align #(.WW(WW)) u_align (
    .clk(clk), .rst_n(rst_n), .rx_bit(rx_bit),
    .comma_hit(comma_hit_w), .locked(locked_w),
    .word_q(word_out), .word_valid_q(word_valid)
  );

  cwc_word_check #(.BW(BW)) u_check (
    .enable(data_mode && locked_w), .dec_valid(dec_valid),
    .dec_byte(dec_byte), .dec_parity(dec_parity), .tx_byte(tx_byte),
    .good_w(good_w), .bad_w(bad_w), .par_bad_w(par_bad_w)
  );

  cwc_pulse_out u_pulse (
    .clk(clk), .rst_n(rst_n), .data_mode(data_mode),
    .comma_hit(comma_hit_w), .good_w(good_w), .bad_w(bad_w),
    .par_bad_w(par_bad_w), .hit_q(hit_pulse), .fault_q(fault_pulse),
    .par_q(parity_err_pulse)
  );
endmodule

// File: rtl/cwc_checker.sv
module cwc_checker (
  input logic clk,
  input logic rst_n,
  input logic data_mode,
  input logic dec_valid,
  input logic comma_hit,
  input logic locked,
  input logic word_valid,
  input logic hit_pulse,
  input logic fault_pulse,
  input logic parity_err_pulse
);
  // R7
  hit_fault_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(hit_pulse && fault_pulse));

  // R8
  par_implies_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    parity_err_pulse |-> fault_pulse);

  // R4
  quiet_unlocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!locked && !comma_hit) |=> (!word_valid && !fault_pulse && !parity_err_pulse && !hit_pulse));

  // R2
  comma_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    comma_hit |=> word_valid);

  // R5
  comma_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (comma_hit && !data_mode) |=> hit_pulse);

  // R5
  comma_mode_nofault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !data_mode |=> !fault_pulse);

  // R9
  idle_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_mode && !dec_valid) |=> (!hit_pulse && !fault_pulse));
endmodule

bind comma_word_checker cwc_checker u_chk (
  .clk(clk), .rst_n(rst_n), .data_mode(data_mode), .dec_valid(dec_valid),
  .comma_hit(comma_hit_w), .locked(locked_w), .word_valid(word_valid),
  .hit_pulse(hit_pulse), .fault_pulse(fault_pulse),
  .parity_err_pulse(parity_err_pulse)
);

// File: tb/comma_word_checker_tb.sv
module comma_word_checker_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic data_mode = 1'b0, rx_bit = 1'b0, dec_valid = 1'b0, dec_parity = 1'b0;
  logic [7:0] dec_byte = '0, tx_byte = '0;
  logic [9:0] word_out;
  logic word_valid, hit_pulse, fault_pulse, parity_err_pulse;

  int checks = 0, failures = 0;
  int wv_cnt = 0, hit_cnt = 0;
  logic altb = 1'b1;
  bit done = 1'b0;

  localparam logic [9:0] K_POS = 10'b0011111010;
  localparam logic [9:0] K_NEG = 10'b1100000101;
  localparam logic [9:0] D_ALT = 10'b1010101010;
  localparam logic [9:0] D_X   = 10'b0110110110;

  // {byte, parity, tx, exp_hit, exp_fault, exp_par}
  localparam int NV = 7;
  localparam logic [19:0] VEC [NV] = '{
    {8'hA5, 1'b0, 8'hA5, 3'b100},
    {8'hA5, 1'b1, 8'hA5, 3'b011},
    {8'h3C, 1'b0, 8'h3D, 3'b010},
    {8'h07, 1'b1, 8'h07, 3'b100},
    {8'hFF, 1'b0, 8'hFF, 3'b100},
    {8'h00, 1'b0, 8'h01, 3'b010},
    {8'h80, 1'b0, 8'h80, 3'b011}
  };

  always #2.5 clk = ~clk;

  comma_word_checker u_dut (
    .clk(clk), .rst_n(rst_n), .data_mode(data_mode), .rx_bit(rx_bit),
    .dec_valid(dec_valid), .dec_byte(dec_byte), .dec_parity(dec_parity),
    .tx_byte(tx_byte), .word_out(word_out), .word_valid(word_valid),
    .hit_pulse(hit_pulse), .fault_pulse(fault_pulse),
    .parity_err_pulse(parity_err_pulse)
  );

  always @(negedge clk) if (rst_n) begin
    if (word_valid) wv_cnt++;
    if (hit_pulse) hit_cnt++;
  end

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input logic b);
    rx_bit = b;
    @(posedge clk);
    #1;
  endtask

  task automatic step_alt();
    step(altb);
    altb = ~altb;
  endtask

  task automatic send_bits(input logic [9:0] w, input int hi, input int lo);
    for (int i = hi; i >= lo; i--) step(w[i]);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R4 reset state
    chk({word_valid, hit_pulse, fault_pulse, parity_err_pulse} == 4'b0, "R4 reset",
        {word_valid, hit_pulse, fault_pulse, parity_err_pulse}, 0);
    rst_n = 1'b1;

    // R4: decoder results before any comma are ignored
    data_mode = 1'b1; dec_valid = 1'b1; dec_byte = 8'hA5; dec_parity = 1'b0; tx_byte = 8'hA5;
    step_alt();
    dec_valid = 1'b0;
    chk(!hit_pulse && !fault_pulse, "R4 unlocked check", {hit_pulse, fault_pulse}, 0);
    for (int i = 0; i < 20; i++) step_alt();
    chk(wv_cnt == 0, "R4 no words before comma", wv_cnt, 0);

    // R1 R2 R5: comma mode, positive comma
    data_mode = 1'b0;
    altb = 1'b1;
    send_bits(K_POS, 9, 0);
    step(D_ALT[9]);
    chk(word_valid && word_out == K_POS, "R2 comma capture", word_out, K_POS);
    chk(hit_pulse, "R5 comma pulse", hit_pulse, 1);
    step(D_ALT[8]);
    chk(!hit_pulse && !word_valid, "R9 one-cycle pulse", {hit_pulse, word_valid}, 0);
    send_bits(D_ALT, 7, 0);
    step(K_NEG[9]);
    chk(word_valid && word_out == D_ALT, "R3 word after ten bits", word_out, D_ALT);
    send_bits(K_NEG, 8, 0);
    step(D_ALT[9]);
    chk(word_valid && word_out == K_NEG, "R1 negative comma capture", word_out, K_NEG);
    chk(hit_pulse, "R1 negative comma pulse", hit_pulse, 1);
    send_bits(D_ALT, 8, 0);

    // R3: realign at an offset
    step(1'b1); step(1'b0); step(1'b1);
    send_bits(K_POS, 9, 0);
    step(D_X[9]);
    chk(word_valid && word_out == K_POS, "R3 realign comma", word_out, K_POS);
    send_bits(D_X, 8, 0);
    step(1'b1);
    chk(word_valid && word_out == D_X, "R3 word on new boundary", word_out, D_X);
    altb = 1'b0;
    for (int i = 0; i < 9; i++) step_alt();

    // R5: decoder interface has no effect in comma mode
    dec_valid = 1'b1; dec_byte = 8'hA5; dec_parity = 1'b1; tx_byte = 8'h00;
    step_alt();
    dec_valid = 1'b0;
    chk(!fault_pulse && !parity_err_pulse, "R5 comma mode ignores decoder",
        {fault_pulse, parity_err_pulse}, 0);

    // R6 R7 R8 R9: data mode vector table
    data_mode = 1'b1;
    for (int v = 0; v < NV; v++) begin
      dec_byte = VEC[v][19:12]; dec_parity = VEC[v][11]; tx_byte = VEC[v][10:3];
      dec_valid = 1'b1;
      step_alt();
      dec_valid = 1'b0;
      chk(hit_pulse == VEC[v][2], "R6 match pulse", hit_pulse, VEC[v][2]);
      chk(fault_pulse == VEC[v][1], "R7 fault pulse", fault_pulse, VEC[v][1]);
      chk(parity_err_pulse == VEC[v][0], "R8 parity pulse", parity_err_pulse, VEC[v][0]);
      step_alt();
      chk({hit_pulse, fault_pulse, parity_err_pulse} == 3'b0, "R9 pulse ends",
          {hit_pulse, fault_pulse, parity_err_pulse}, 0);
    end

    // R10: comma in data mode captures but does not pulse hit
    begin
      int h0;
      for (int i = 0; i < 4; i++) step_alt();
      h0 = hit_cnt;
      send_bits(K_NEG, 9, 0);
      step(1'b0);
      chk(word_valid && word_out == K_NEG, "R10 data-mode comma capture", word_out, K_NEG);
      chk(!hit_pulse, "R10 no hit on data-mode comma", hit_pulse, 0);
      step(1'b1);
      chk(hit_cnt == h0, "R10 hit count unchanged", hit_cnt, h0);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule